// File: doc/BRIEF.md
# DMA Transfer-End Strobe Generator

This block drives an active-low end-of-transfer strobe for one DMA channel. A start pulse arms the channel with a transfer count, a 2-bit position select and a flag that says whether the request comes from an external peripheral. The channel's transfer engine then reports two events per data transfer: a read-cycle start and a write-cycle completion. An internal down-counter, decremented on each accepted write completion, marks which read/write pair is the final one.

Three cycles can carry the strobe, depending on the position select. It can follow the start of the final read, follow the completion of the final write, or coincide with the transfer-end interrupt. The select can also turn the strobe off. The block raises the transfer-end interrupt itself and drops the channel's active flag in that same cycle. For transfers requested by an external peripheral, the strobe is held inactive whatever the select says.

Top module: `dmaend_strobe_gen`

## Requirements
- R1: After a synchronous active-high reset the strobe `end_n` is 1, `end_irq` is 0 and `active` is 0.
- R2: A `start` pulse while `active` is 0 and with a non-zero `start_count` makes `active` 1 in the next cycle. A `start` while `active` is 1, or with a count of zero, has no effect.
- R3: With `pos_sel` = 2'b00 the strobe stays 1 for the whole transfer and after it.
- R4: With `pos_sel` = 2'b01 the strobe is 0 for exactly one cycle: the cycle right after the one in which the final read start (remaining count 1) is presented.
- R5: With `pos_sel` = 2'b10 the strobe is 0 for exactly one cycle: the cycle right after the one in which the final write completion is presented.
- R6: With `pos_sel` = 2'b11 the strobe is 0 for exactly one cycle, the same cycle in which `end_irq` is 1.
- R7: `end_irq` is a single-cycle pulse two cycles after the final write completion is presented, and `active` is 0 from that cycle on.
- R8: When `ext_src` = 1 at start, the strobe stays 1 in every mode, while `end_irq` is still produced.
- R9: A count of 1 makes the only read/write pair the final one, so each strobe-producing mode gives exactly one pulse.
- R10: `pos_sel` and `ext_src` are captured on an accepted start; later changes to them during the transfer have no effect.
- R11: `rd_start` and `wr_done` while `active` is 0 produce no strobe and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm request; loads count and captures configuration |
| start_count | input | CNT_W | Number of read/write pairs in the transfer |
| pos_sel | input | 2 | Strobe position: 00 off, 01 after last read, 10 after last write, 11 with interrupt |
| ext_src | input | 1 | 1 when the request comes from an external peripheral |
| rd_start | input | 1 | One-cycle pulse: a read cycle starts |
| wr_done | input | 1 | One-cycle pulse: a write cycle completes |
| end_n | output | 1 | Active-low end-of-transfer strobe |
| end_irq | output | 1 | Transfer-end interrupt pulse |
| active | output | 1 | Channel armed and transferring |

## Verification
Every position select is tried with counts of 1 and of several pairs. The pulse position is measured against the cycle of the final read start and the final write completion, which separates the after-read, after-write and with-interrupt positions. Here an off-by-one in the counter shows up as a pulse on the wrong pair. The external-request flag is set with strobe-producing modes to show that it suppresses only the strobe and not the interrupt. Separate runs change the select and the flag in mid-transfer, re-arm while active, arm with a zero count, and send stray events while idle, each of which must leave the outputs unchanged.

// File: rtl/dmaend_pkg.sv
package dmaend_pkg;

    typedef enum logic [1:0] {
        END_OFF      = 2'b00,
        END_AT_READ  = 2'b01,
        END_AT_WRITE = 2'b10,
        END_AT_IRQ   = 2'b11
    } end_mode_e;

    typedef struct packed {
        end_mode_e mode;
        logic      ext;
    } end_cfg_t;

    localparam end_cfg_t CFG_RESET = '{mode: END_OFF, ext: 1'b0};

    // strobe allowed for this trigger point under the captured config
    function automatic logic strobe_enabled(end_cfg_t cfg, end_mode_e point);
        return (cfg.mode == point) && !cfg.ext;
    endfunction

endpackage

// File: rtl/dmaend_ctrl.sv
module dmaend_ctrl
    import dmaend_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic [1:0]       pos_sel,
    input  logic             ext_src,
    input  logic             finish,
    output logic             accept,
    output logic             active,
    output end_cfg_t         cfg
);

    assign accept = start && !active && (start_count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cfg    <= CFG_RESET;
        end else if (accept) begin
            active   <= 1'b1;
            cfg.mode <= end_mode_e'(pos_sel);
            cfg.ext  <= ext_src;
        end else if (finish) begin
            active <= 1'b0;
        end
    end

endmodule

// File: rtl/dmaend_count.sv
module dmaend_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last,
    output logic             is_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign is_last = (remain == ONE);
    assign is_zero = (remain == '0);

endmodule

// File: rtl/dmaend_irq_seq.sv
module dmaend_irq_seq (
    input  logic clk,
    input  logic rst,
    input  logic final_wr,
    output logic done_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            done_q <= final_wr;
            irq    <= done_q;
        end
    end

endmodule

// File: rtl/dmaend_strobe.sv
module dmaend_strobe
    import dmaend_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  end_cfg_t cfg,
    input  logic     final_rd,
    input  logic     final_wr,
    input  logic     irq_next,
    output logic     end_n
);

    logic fire;

    always_comb begin
        fire = 1'b0;
        if (final_rd && strobe_enabled(cfg, END_AT_READ))  fire = 1'b1;
        if (final_wr && strobe_enabled(cfg, END_AT_WRITE)) fire = 1'b1;
        if (irq_next && strobe_enabled(cfg, END_AT_IRQ))   fire = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) end_n <= 1'b1;
        else     end_n <= !fire;
    end

endmodule

// File: rtl/dmaend_strobe_gen.sv
module dmaend_strobe_gen
    import dmaend_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic [1:0]       pos_sel,
    input  logic             ext_src,
    input  logic             rd_start,
    input  logic             wr_done,
    output logic             end_n,
    output logic             end_irq,
    output logic             active
);

    logic     accept, is_last, is_zero, done_q;
    logic     rd_ev, wr_ev, final_rd, final_wr;
    end_cfg_t cfg;

    dmaend_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_count(start_count),
        .pos_sel(pos_sel), .ext_src(ext_src), .finish(done_q),
        .accept(accept), .active(active), .cfg(cfg)
    );

    assign rd_ev    = active && rd_start && !is_zero;
    assign wr_ev    = active && wr_done && !is_zero;
    assign final_rd = rd_ev && is_last;
    assign final_wr = wr_ev && is_last;

    dmaend_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .load(accept), .load_val(start_count),
        .dec(wr_ev), .is_last(is_last), .is_zero(is_zero)
    );

    dmaend_irq_seq u_irq (
        .clk(clk), .rst(rst), .final_wr(final_wr),
        .done_q(done_q), .irq(end_irq)
    );

    dmaend_strobe u_strobe (
        .clk(clk), .rst(rst), .cfg(cfg), .final_rd(final_rd),
        .final_wr(final_wr), .irq_next(done_q), .end_n(end_n)
    );

    // R4 R5 R6: every strobe pulse lasts a single cycle
    a_r4_single_low: assert property (@(posedge clk) disable iff (rst)
        !end_n |=> end_n);

    // R6: with-interrupt mode pulses only alongside the interrupt
    a_r6_with_irq: assert property (@(posedge clk) disable iff (rst)
        (!end_n && cfg.mode == END_AT_IRQ) |-> end_irq);

    // R7: interrupt is one cycle wide
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        end_irq |=> !end_irq);

    // R7: channel is released when the interrupt is raised
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        end_irq |-> !active);

    // R8: external requests never drive the strobe
    a_r8_ext_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg.ext |-> end_n);

    // R3: off mode never drives the strobe
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg.mode == END_OFF |-> end_n);

    // R11: interrupt only follows an armed channel
    a_r11_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(end_irq) |-> $past(active));

endmodule

// File: tb/dmaend_strobe_gen_tb.sv
module dmaend_strobe_gen_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] start_count = '0;
    logic [1:0]       pos_sel = 2'b00;
    logic             ext_src = 1'b0;
    logic             rd_start = 1'b0;
    logic             wr_done = 1'b0;
    logic             end_n, end_irq, active;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int low_cnt, low_at, irq_cnt, irq_at;
    bit mon_on   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    dmaend_strobe_gen #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_count(start_count),
        .pos_sel(pos_sel), .ext_src(ext_src), .rd_start(rd_start),
        .wr_done(wr_done), .end_n(end_n), .end_irq(end_irq), .active(active)
    );

    always @(negedge clk) begin
        if (mon_on) begin
            if (!end_n) begin low_cnt++; low_at = cyc; end
            if (end_irq) begin irq_cnt++; irq_at = cyc; end
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic clear_mon();
        low_cnt = 0; low_at = -1; irq_cnt = 0; irq_at = -1;
        mon_on  = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one transfer; flips pos_sel/ext_src after arming (R10)
    task automatic xfer(input logic [1:0] mode, input logic ext, input int cnt,
                        input string req, input bit restart_mid);
        int rd_last = 0, wr_last = 0, exp_low;
        @(negedge clk);
        clear_mon();
        start = 1'b1; start_count = CNT_W'(cnt); pos_sel = mode; ext_src = ext;
        @(negedge clk);
        start = 1'b0; pos_sel = ~mode; ext_src = ~ext;
        check({req, " R2 armed"}, int'(active), 1);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); rd_start = 1'b1; rd_last = cyc;
            if (restart_mid && i == 0) begin
                start = 1'b1; start_count = CNT_W'(cnt + 5);
            end
            @(negedge clk); rd_start = 1'b0; start = 1'b0;
            @(negedge clk); wr_done = 1'b1; wr_last = cyc;
            @(negedge clk); wr_done = 1'b0;
        end
        idle(4);
        mon_on = 1'b0;
        exp_low = (mode == 2'b00 || ext) ? 0 : 1;
        check({req, " pulse count"}, low_cnt, exp_low);
        if (exp_low == 1) begin
            case (mode)
                2'b01:   check({req, " R4 pulse after last read"},  low_at, rd_last + 1);
                2'b10:   check({req, " R5 pulse after last write"}, low_at, wr_last + 1);
                default: check({req, " R6 pulse with irq"},          low_at, wr_last + 2);
            endcase
        end
        check({req, " R7 irq count"}, irq_cnt, 1);
        check({req, " R7 irq cycle"}, irq_at, wr_last + 2);
        check({req, " R7 released"}, int'(active), 0);
        check({req, " strobe idle"}, int'(end_n), 1);
    endtask

    task automatic t_reset();
        check("R1 strobe", int'(end_n), 1);
        check("R1 irq", int'(end_irq), 0);
        check("R1 active", int'(active), 0);
    endtask

    task automatic t_zero_count();
        @(negedge clk);
        start = 1'b1; start_count = '0; pos_sel = 2'b11;
        @(negedge clk);
        start = 1'b0;
        check("R2 zero count not armed", int'(active), 0);
    endtask

    task automatic t_stray();
        @(negedge clk);
        clear_mon();
        pos_sel = 2'b01;
        rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0; wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
        idle(4);
        mon_on = 1'b0;
        check("R11 no strobe when idle", low_cnt, 0);
        check("R11 no irq when idle", irq_cnt, 0);
        check("R11 still idle", int'(active), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        xfer(2'b00, 1'b0, 3, "R3 off", 1'b0);
        xfer(2'b01, 1'b0, 3, "R4 read", 1'b0);
        xfer(2'b10, 1'b0, 4, "R5 write", 1'b0);
        xfer(2'b11, 1'b0, 2, "R6 irq", 1'b0);
        xfer(2'b01, 1'b1, 3, "R8 ext read", 1'b0);
        xfer(2'b11, 1'b1, 2, "R8 ext irq", 1'b0);
        xfer(2'b01, 1'b0, 1, "R9 single read", 1'b0);
        xfer(2'b10, 1'b0, 1, "R9 single write", 1'b0);
        xfer(2'b11, 1'b0, 1, "R9 single irq", 1'b0);
        xfer(2'b10, 1'b0, 3, "R10 R2 restart ignored", 1'b1);
        t_zero_count();
        t_stray();
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule